// File: doc/BRIEF.md
# Clustered Decode Steering and Merge

This block sits between a fetch-block source and a rename port. Each incoming fetch block is given as a start address and an instruction count, and the block ends at a predicted taken branch. Any block longer than one micro-op queue is first cut into pieces of at most 32 instructions. Pieces are handed out in strict rotation to three decode clusters, so several upcoming start points are in flight together. Each cluster expands its piece into micro-ops, at up to three per cycle, and writes them into a private 32-entry queue.

Decoding is abstract. Instruction number `k` of a piece starting at address `A` yields one micro-op whose tag is `A + k`. A merge stage reads the three queues in original program order and delivers up to eight micro-ops per cycle on a valid/ready rename port. It always drains the cluster that holds the oldest unfinished piece. Once that piece's final micro-op is taken, it moves to the next cluster in rotation, and it can do so in the middle of a cycle.

A flush input drops all queued and pending work and restarts the rotation at cluster zero.

Top module: `decode_steer_merge`

## Requirements
- R1: After reset `renValid` is 0 and `inReady` is 1.
- R2: Every instruction of every accepted block leaves the rename port exactly once, with tag = block start + instruction index. Order follows program order: lane 0 before lane 1, and so on, and earlier cycles before later ones. Lane `i` occupies `renTags[16*i +: 16]`.
- R3: Each transfer carries `renCount` micro-ops, between 1 and 8, packed from lane 0, and `renValid` is 1 exactly when `renCount` is nonzero. One transfer may hold micro-ops from several consecutive blocks that were decoded by different clusters.
- R4: A block of more than 32 instructions is cut into pieces of at most 32, which go to successive clusters. With the rename port always ready, a 96-instruction block is fully delivered within 28 cycles of its acceptance, and some cycle carries 8 micro-ops.
- R5: Pieces are assigned to clusters in strict round-robin order, and each piece carries a sequence number that advances by one per piece.
- R6: A cluster writes at most 3 micro-ops per cycle, and it neither decodes nor accepts a piece while its queue has fewer than 3 free entries. With the rename port blocked for a long time, no micro-op is lost or duplicated.
- R7: While `renReady` is 0, no queue entry is consumed, and lane 0 keeps presenting the oldest undelivered micro-op.
- R8: In the cycle after `flush` is high, `renValid` is 0. All queued and pending work is discarded, and delivery then resumes with the first block accepted after the flush.
- R9: A block with a count of zero is accepted and produces no micro-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all work; rotation back to cluster 0 |
| inValid | input | 1 | Fetch block offered |
| inReady | output | 1 | Fetch block taken when high together with `inValid` |
| inAddr | input | 16 | Start address of the fetch block |
| inCount | input | CNT_W (8) | Instructions in the block, up to the predicted taken branch |
| renReady | input | 1 | Rename port can take this cycle's micro-ops |
| renValid | output | 1 | At least one micro-op presented |
| renCount | output | 4 | Number of valid lanes, 0 to 8 |
| renTags | output | 128 | Eight 16-bit micro-op tags, lane 0 in the low bits |

## Verification
The two functions that can fall in the same cycle are finishing one cluster's block and continuing into the next cluster's block inside a single eight-lane transfer. The bench holds the rename port low while four short blocks of 2, 1, 3 and 2 instructions are decoded across the rotation. It then releases the port and expects one transfer of exactly 8 lanes whose tags run through all four blocks in order. The long-block timing test also crosses cluster boundaries mid-cycle, and its tag order is checked against the expected stream built in the bench.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int NCLU   = 3;
  localparam int DEC_W  = 3;
  localparam int QDEPTH = 32;
  localparam int REN_W  = 8;
  localparam int TAG_W  = 16;
  localparam int SEQ_W  = 6;

  localparam int CLU_W  = $clog2(NCLU);
  localparam int QCNT_W = $clog2(QDEPTH + 1);
  localparam int DNUM_W = $clog2(DEC_W + 1);
  localparam int LCNT_W = $clog2(REN_W + 1);
  localparam int LANE_W = $clog2(REN_W);
  localparam int PTR_W  = $clog2(QDEPTH);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [SEQ_W-1:0] seq;
    logic             last;
  } uop_t;

  typedef struct packed {
    logic [DNUM_W-1:0] num;
    logic [TAG_W-1:0]  base;
    logic [SEQ_W-1:0]  seq;
    logic              endsBlk;
  } wr_t;

  typedef struct packed {
    logic            clr;
    wr_t [NCLU-1:0]  wr;
  } strobe_t;
endpackage

// File: rtl/dsm_steer_ctrl.sv
module dsm_steer_ctrl
  import dsm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         inValid,
  input  logic [TAG_W-1:0]             inAddr,
  input  logic [CNT_W-1:0]             inCount,
  input  logic [NCLU-1:0][QCNT_W-1:0]  freeCnt,
  output logic                         inReady,
  output strobe_t                      stb
);
  localparam int PLEN_W = QCNT_W;

  logic               regAct;
  logic [TAG_W-1:0]   regAddr;
  logic [CNT_W-1:0]   regLeft;
  logic [CLU_W-1:0]   rrPtr;
  logic [SEQ_W-1:0]   seqCnt;

  logic [NCLU-1:0]    cBusy;
  logic [TAG_W-1:0]   cAddr [NCLU];
  logic [PLEN_W-1:0]  cLeft [NCLU];
  logic [SEQ_W-1:0]   cSeq  [NCLU];

  logic [PLEN_W-1:0]  pieceLen;
  logic               lastPiece;
  logic               issue;
  logic               accept;
  logic [NCLU-1:0]    canDec;
  logic [DNUM_W-1:0]  decNum [NCLU];

  // Region splitting and dispatch decision
  always_comb begin
    lastPiece = (32'(regLeft) <= QDEPTH);
    pieceLen  = lastPiece ? PLEN_W'(regLeft) : PLEN_W'(QDEPTH);
    issue     = regAct && !flush && !cBusy[rrPtr] &&
                (freeCnt[rrPtr] >= QCNT_W'(DEC_W));
    inReady   = !flush && (!regAct || (issue && lastPiece));
    accept    = inValid && inReady;
  end

  // Per-cluster decode stepping
  always_comb begin
    stb.clr = flush;
    for (int c = 0; c < NCLU; c++) begin
      canDec[c] = cBusy[c] && !flush && (freeCnt[c] >= QCNT_W'(DEC_W));
      decNum[c] = (cLeft[c] >= PLEN_W'(DEC_W)) ? DNUM_W'(DEC_W)
                                               : DNUM_W'(cLeft[c]);
      stb.wr[c].num     = canDec[c] ? decNum[c] : '0;
      stb.wr[c].base    = cAddr[c];
      stb.wr[c].seq     = cSeq[c];
      stb.wr[c].endsBlk = (cLeft[c] <= PLEN_W'(DEC_W));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAct  <= 1'b0;
      regAddr <= '0;
      regLeft <= '0;
      rrPtr   <= '0;
      seqCnt  <= '0;
      cBusy   <= '0;
      for (int c = 0; c < NCLU; c++) begin
        cAddr[c] <= '0;
        cLeft[c] <= '0;
        cSeq[c]  <= '0;
      end
    end else if (flush) begin
      regAct  <= 1'b0;
      regLeft <= '0;
      rrPtr   <= '0;
      seqCnt  <= '0;
      cBusy   <= '0;
      for (int c = 0; c < NCLU; c++) begin
        cLeft[c] <= '0;
      end
    end else begin
      if (accept) begin
        regAct  <= (inCount != '0);
        regAddr <= inAddr;
        regLeft <= inCount;
      end else if (issue) begin
        regAddr <= regAddr + TAG_W'(pieceLen);
        regLeft <= regLeft - CNT_W'(pieceLen);
        regAct  <= !lastPiece;
      end
      if (issue) begin
        rrPtr  <= (rrPtr == CLU_W'(NCLU - 1)) ? '0 : rrPtr + 1'b1;
        seqCnt <= seqCnt + 1'b1;
      end
      for (int c = 0; c < NCLU; c++) begin
        if (issue && (rrPtr == CLU_W'(c))) begin
          cBusy[c] <= 1'b1;
          cAddr[c] <= regAddr;
          cLeft[c] <= pieceLen;
          cSeq[c]  <= seqCnt;
        end else if (canDec[c]) begin
          cAddr[c] <= cAddr[c] + TAG_W'(decNum[c]);
          cLeft[c] <= cLeft[c] - PLEN_W'(decNum[c]);
          if (cLeft[c] <= PLEN_W'(DEC_W)) cBusy[c] <= 1'b0;
        end
      end
    end
  end

  // R5
  rr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue |=> (rrPtr != $past(rrPtr)) && (seqCnt == $past(seqCnt) + 1'b1));

  for (genvar g = 0; g < NCLU; g++) begin : g_piece
    // R4
    piece_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      cBusy[g] |-> (cLeft[g] != '0) && (32'(cLeft[g]) <= QDEPTH));
  end
endmodule

// File: rtl/dsm_uop_queue.sv
module dsm_uop_queue
  import dsm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                clr,
  input  wr_t                 wr,
  input  logic [LCNT_W-1:0]   rdNum,
  output logic [QCNT_W-1:0]   count,
  output uop_t [REN_W-1:0]    peek
);
  uop_t             mem [QDEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (!clr) begin
      for (int i = 0; i < DEC_W; i++) begin
        if (DNUM_W'(i) < wr.num) begin
          mem[wrPtr + PTR_W'(i)].tag  <= wr.base + TAG_W'(i);
          mem[wrPtr + PTR_W'(i)].seq  <= wr.seq;
          mem[wrPtr + PTR_W'(i)].last <= wr.endsBlk && (DNUM_W'(i + 1) == wr.num);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(wr.num);
      rdPtr <= rdPtr + PTR_W'(rdNum);
      count <= count + QCNT_W'(wr.num) - QCNT_W'(rdNum);
    end
  end

  always_comb begin
    for (int k = 0; k < REN_W; k++) begin
      peek[k] = mem[rdPtr + PTR_W'(k)];
    end
  end

  // R6
  qfull_guard_chk: assert property (@(posedge clk) disable iff (!rstN || clr)
    (wr.num != '0) |-> (32'(count) + 32'(wr.num) <= QDEPTH));

  // R7
  rd_bound_chk: assert property (@(posedge clk) disable iff (!rstN || clr)
    32'(rdNum) <= 32'(count));
endmodule

// File: rtl/dsm_merge_dp.sv
module dsm_merge_dp
  import dsm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic                          renReady,
  output logic [NCLU-1:0][QCNT_W-1:0]   freeCnt,
  output logic                          renValid,
  output logic [LCNT_W-1:0]             renCount,
  output logic [REN_W-1:0][TAG_W-1:0]   renLanes
);
  logic [QCNT_W-1:0]  qCount [NCLU];
  uop_t [REN_W-1:0]   qPeek  [NCLU];
  logic [LCNT_W-1:0]  rdNum  [NCLU];
  logic [LCNT_W-1:0]  taken  [NCLU];

  logic [CLU_W-1:0]   headPtr;
  logic [CLU_W-1:0]   walkCur;
  logic               walkStop;
  uop_t               ent;
  logic [REN_W-1:0]   laneV;
  logic [SEQ_W-1:0]   laneSeq [REN_W];
  logic [LCNT_W-1:0]  nLanes;
  logic               fire;

  for (genvar g = 0; g < NCLU; g++) begin : g_q
    dsm_uop_queue u_q (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (stb.clr),
      .wr    (stb.wr[g]),
      .rdNum (rdNum[g]),
      .count (qCount[g]),
      .peek  (qPeek[g])
    );
    assign freeCnt[g] = QCNT_W'(QDEPTH) - qCount[g];
  end

  // Ordered walk over the queues, starting at the oldest cluster
  always_comb begin
    walkCur  = headPtr;
    walkStop = 1'b0;
    ent      = '0;
    laneV    = '0;
    nLanes   = '0;
    renLanes = '0;
    for (int c = 0; c < NCLU; c++) taken[c] = '0;
    for (int l = 0; l < REN_W; l++) begin
      laneSeq[l] = '0;
      if (!walkStop) begin
        if (32'(taken[walkCur]) < 32'(qCount[walkCur])) begin
          ent              = qPeek[walkCur][taken[walkCur][LANE_W-1:0]];
          laneV[l]         = 1'b1;
          renLanes[l]      = ent.tag;
          laneSeq[l]       = ent.seq;
          taken[walkCur]   = taken[walkCur] + 1'b1;
          nLanes           = nLanes + 1'b1;
          if (ent.last) begin
            walkCur = (walkCur == CLU_W'(NCLU - 1)) ? '0 : walkCur + 1'b1;
          end
        end else begin
          walkStop = 1'b1;
        end
      end
    end
  end

  always_comb begin
    renValid = (nLanes != '0);
    renCount = nLanes;
    fire     = renValid && renReady;
    for (int c = 0; c < NCLU; c++) rdNum[c] = fire ? taken[c] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        headPtr <= '0;
    else if (stb.clr) headPtr <= '0;
    else if (fire)    headPtr <= walkCur;
  end

  for (genvar l = 1; l < REN_W; l++) begin : g_lane
    // R2
    lane_order_chk: assert property (@(posedge clk) disable iff (!rstN)
      laneV[l] |-> laneV[l-1] &&
        ((laneSeq[l] == laneSeq[l-1] && renLanes[l] == renLanes[l-1] + 1'b1) ||
         (laneSeq[l] == laneSeq[l-1] + 1'b1)));
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    renValid && !renReady && !stb.clr |=> renValid && $stable(renLanes[0]));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> !renValid);
endmodule

// File: rtl/decode_steer_merge.sv
module decode_steer_merge
  import dsm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [TAG_W-1:0]         inAddr,
  input  logic [CNT_W-1:0]         inCount,
  input  logic                     renReady,
  output logic                     renValid,
  output logic [LCNT_W-1:0]        renCount,
  output logic [REN_W*TAG_W-1:0]   renTags
);
  strobe_t                        stb;
  logic [NCLU-1:0][QCNT_W-1:0]    freeCnt;
  logic [REN_W-1:0][TAG_W-1:0]    renLanes;

  dsm_steer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .flush   (flush),
    .inValid (inValid),
    .inAddr  (inAddr),
    .inCount (inCount),
    .freeCnt (freeCnt),
    .inReady (inReady),
    .stb     (stb)
  );

  dsm_merge_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .renReady (renReady),
    .freeCnt  (freeCnt),
    .renValid (renValid),
    .renCount (renCount),
    .renLanes (renLanes)
  );

  assign renTags = renLanes;
endmodule

// File: tb/decode_steer_merge_tb.sv
`timescale 1ns/1ps
module decode_steer_merge_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         flush = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [15:0]  inAddr = '0;
  logic [7:0]   inCount = '0;
  logic         renReady = 1'b1;
  logic         renValid;
  logic [3:0]   renCount;
  logic [127:0] renTags;

  decode_steer_merge dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inCount(inCount), .renReady(renReady), .renValid(renValid),
    .renCount(renCount), .renTags(renTags)
  );

  always #10 clk = ~clk;

  int nChk = 0;
  int nErr = 0;
  int cyc = 0;
  int wrIdx = 0;
  int rdIdx = 0;
  int lastCyc = 0;
  int maxLanes = 0;
  int startCyc = 0;
  logic [15:0] expQ [0:2047];

  // {start address, count, cycles of blocked rename after the push}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {16'h1000, 8'd5,   8'd0},  {16'h1100, 8'd1,   8'd0},
    {16'h1200, 8'd3,   8'd0},  {16'h1300, 8'd0,   8'd0},
    {16'h1400, 8'd12,  8'd0},  {16'h1500, 8'd40,  8'd10},
    {16'h1600, 8'd2,   8'd0},  {16'h1700, 8'd33,  8'd0},
    {16'h2000, 8'd100, 8'd80}, {16'h2100, 8'd7,   8'd5},
    {16'h2200, 8'd64,  8'd0},  {16'h2300, 8'd9,   8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChk++;
      nErr++;
      $display("FAIL R2: watchdog expired, delivered %0d expected %0d", rdIdx, wrIdx);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

  // Output monitor: compare every delivered micro-op against the expected stream
  always @(negedge clk) begin
    if (rstN && !flush) begin
      chk(renValid == (renCount != 0), "R3", int'(renValid), int'(renCount != 0));
      if (renValid && renReady) begin
        chk(renCount <= 8, "R3", int'(renCount), 8);
        for (int l = 0; l < 8; l++) begin
          if (l < int'(renCount)) begin
            if (rdIdx < wrIdx)
              chk(renTags[l*16 +: 16] == expQ[rdIdx], "R2",
                  int'(renTags[l*16 +: 16]), int'(expQ[rdIdx]));
            else
              chk(1'b0, "R2", int'(renTags[l*16 +: 16]), 0);
            rdIdx++;
          end
        end
        lastCyc = cyc;
        if (int'(renCount) > maxLanes) maxLanes = int'(renCount);
      end
    end
  end

  task automatic pushBlk(input logic [15:0] a, input logic [7:0] n);
    @(posedge clk); #1;
    inValid = 1'b1;
    inAddr  = a;
    inCount = n;
    do @(negedge clk); while (!inReady);
    for (int i = 0; i < int'(n); i++) begin
      expQ[wrIdx] = a + 16'(i);
      wrIdx++;
    end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic blockOut(input int n);
    renReady = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (renValid)
        chk(renTags[15:0] == expQ[rdIdx], "R7", int'(renTags[15:0]), int'(expQ[rdIdx]));
    end
    @(posedge clk); #1;
    renReady = 1'b1;
  endtask

  task automatic drain();
    int t = 0;
    while (rdIdx < wrIdx && t < 3000) begin
      @(posedge clk);
      t++;
    end
    chk(rdIdx == wrIdx, "R6", rdIdx, wrIdx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(renValid == 1'b0, "R1", int'(renValid), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(renValid == 1'b0, "R1", int'(renValid), 0);
    chk(inReady == 1'b1, "R1", int'(inReady), 1);

    // Table walk: order, splitting, long stalls (R2, R4, R6, R7)
    for (int v = 0; v < NV; v++) begin
      pushBlk(VEC[v][31:16], VEC[v][15:8]);
      if (VEC[v][7:0] != 0) blockOut(int'(VEC[v][7:0]));
    end
    drain();

    // R9: zero-count block yields nothing
    pushBlk(16'h3000, 8'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(renValid == 1'b0, "R9", int'(renValid), 0);
    end

    // R3: one transfer spans four short blocks across the rotation
    @(posedge clk); #1;
    renReady = 1'b0;
    pushBlk(16'h3100, 8'd2);
    pushBlk(16'h3200, 8'd1);
    pushBlk(16'h3300, 8'd3);
    pushBlk(16'h3400, 8'd2);
    repeat (15) @(posedge clk);
    #1 renReady = 1'b1;
    @(negedge clk);
    chk(renCount == 4'd8, "R3", int'(renCount), 8);
    drain();

    // R4: long block split across all clusters, rename always ready
    maxLanes = 0;
    pushBlk(16'h4000, 8'd96);
    startCyc = cyc;
    drain();
    chk(lastCyc - startCyc <= 28, "R4", lastCyc - startCyc, 28);
    chk(maxLanes == 8, "R4", maxLanes, 8);

    // R8: flush discards in-flight work
    @(posedge clk); #1;
    renReady = 1'b0;
    pushBlk(16'h6000, 8'd20);
    repeat (4) @(posedge clk);
    #1 flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    rdIdx = wrIdx;
    @(negedge clk);
    chk(renValid == 1'b0, "R8", int'(renValid), 0);
    pushBlk(16'h7000, 8'd5);
    repeat (3) @(negedge clk);
    chk(renValid && renTags[15:0] == 16'h7000, "R8", int'(renTags[15:0]), 16'h7000);
    @(posedge clk); #1;
    renReady = 1'b1;
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule